// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It supports five operations: register add, register subtract, add-with-immediate, word load and word store. Instructions are fetched from an internal instruction array, which is written through a load port while the core is held in reset. Operands come from a 32-entry by 32-bit register file. Loads and stores use a word-wide data memory port whose read path is combinational.

Each cycle proceeds in a fixed order. The word at the program counter is decoded by its opcode, and by its function code when the opcode is zero. The 16-bit immediate is sign-extended. The ALU forms a sum, a difference or a base-plus-offset address. The result, or the loaded word, is written back on the rising clock edge, and the program counter moves on by four.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0x00400000 and every register is cleared to zero. `dmemWrEn` stays low while `rst` is high.
- R2: Out of reset, `pcOut` rises by exactly 4 on every clock edge, whatever the instruction.
- R3: An instruction with opcode bits [31:26] equal to 0 and function bits [5:0] equal to 32 writes rs + rt into rd. The fields are rs at [25:21], rt at [20:16] and rd at [15:11].
- R4: Opcode 0 with function 34 writes rs - rt into rd, with two's complement wrap-around.
- R5: Opcode 8 writes rs plus the sign-extended immediate [15:0] into rt. An immediate of 0x8000 acts as -32768 and 0xFFF4 acts as -12.
- R6: Opcode 35 presents rs + sign-extended immediate on `dmemAddr` and writes `dmemRdData` into rt in the same cycle. It does not raise `dmemWrEn`.
- R7: Opcode 43 raises `dmemWrEn` for one cycle, with `dmemAddr` = rs + sign-extended immediate and `dmemWrData` = the value of rt.
- R8: Register 0 always reads as zero. Any write aimed at it is dropped.
- R9: Any other opcode, and any other function code under opcode 0, writes no register and no memory. The program counter still advances by 4.
- R10: All 31 writable registers hold separate values that are written and read back independently.
- R11: The words 0x8C0A0020, 0x02328020, 0x2268FFF4 and 0x016D4022 execute as: load r10 from address 32; r16 = r17 + r18; r8 = r19 - 12; r8 = r11 - r13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imemLoadEn | input | 1 | Write strobe for the instruction array |
| imemLoadIdx | input | 7 | Word index written in the instruction array |
| imemLoadData | input | 32 | Instruction word to write |
| pcOut | output | 32 | Byte address of the instruction now executing |
| dmemAddr | output | 32 | Byte address for a load or store |
| dmemWrData | output | 32 | Word to store |
| dmemWrEn | output | 1 | Store strobe |
| dmemRdData | input | 32 | Word returned by data memory for `dmemAddr` |

## Verification
State errors in this core leave the block only through the data port and the program counter. A fault in a register, the decode or the ALU therefore shows up as a wrong address or a wrong value on the first store that reads the damaged register. The test program stores each computed value a few instructions after it is produced, so an error appears within a handful of cycles. A stray write, or a missing one, changes the number of store strobes seen. A fault in sequencing shows up at once on `pcOut`.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam logic [XLEN-1:0] RESET_PC = 32'h0040_0000;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef struct packed {
    logic regWrite;
    logic dstIsRd;
    logic immOperand;
    logic subtract;
    logic memWrite;
    logic loadResult;
  } ctrl_t;
endpackage

// File: rtl/rcore_ctrl.sv
module rcore_ctrl
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      strobes
);
  always_comb begin
    strobes = '0;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          strobes.regWrite = 1'b1;
          strobes.dstIsRd  = 1'b1;
          strobes.subtract = (funct == FN_SUB);
        end
      end
      OP_ADDI: begin
        strobes.regWrite   = 1'b1;
        strobes.immOperand = 1'b1;
      end
      OP_LOAD: begin
        strobes.regWrite   = 1'b1;
        strobes.immOperand = 1'b1;
        strobes.loadResult = 1'b1;
      end
      OP_STORE: begin
        strobes.immOperand = 1'b1;
        strobes.memWrite   = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rdIdxA,
  input  logic [AW-1:0]    rdIdxB,
  output logic [WIDTH-1:0] rdValA,
  output logic [WIDTH-1:0] rdValB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrIdx,
  input  logic [WIDTH-1:0] wrVal
);
  logic [WIDTH-1:0] entries [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign entries[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) begin
          entries[i] <= '0;
        end else if (wrEn && wrIdx == AW'(i)) begin
          entries[i] <= wrVal;
        end
      end
    end
  end

  assign rdValA = entries[rdIdxA];
  assign rdValB = entries[rdIdxB];
endmodule

// File: rtl/rcore_imem.sv
module rcore_imem
  import rcore_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            loadEn,
  input  logic [AW-1:0]   loadIdx,
  input  logic [XLEN-1:0] loadData,
  input  logic [XLEN-1:0] fetchAddr,
  output logic [XLEN-1:0] fetchWord
);
  logic [XLEN-1:0] words [WORDS];
  logic [XLEN-1:0] offset;
  logic [AW-1:0]   fetchIdx;
  logic            unusedOffsetBits;

  always_ff @(posedge clk) begin
    if (loadEn) words[loadIdx] <= loadData;
  end

  assign offset    = fetchAddr - RESET_PC;
  assign fetchIdx  = offset[AW+1:2];
  assign fetchWord = words[fetchIdx];
  assign unusedOffsetBits = ^{offset[XLEN-1:AW+2], offset[1:0]};
endmodule

// File: rtl/rcore_datapath.sv
module rcore_datapath
  import rcore_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           strobes,
  input  logic [4:0]      rsIdx,
  input  logic [4:0]      rtIdx,
  input  logic [4:0]      rdIdx,
  input  logic [15:0]     immField,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] rsVal,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic            memWrEn,
  input  logic [XLEN-1:0] memRdData
);
  logic [XLEN-1:0] rtVal;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] operandB;
  logic [XLEN-1:0] aluOut;
  logic [XLEN-1:0] wbVal;
  logic [4:0]      wbIdx;
  logic            wbEn;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc + XLEN'(4);
  end

  assign immExt   = {{(XLEN-16){immField[15]}}, immField};
  assign operandB = strobes.immOperand ? immExt : rtVal;
  assign aluOut   = strobes.subtract ? (rsVal - operandB) : (rsVal + operandB);
  assign wbVal    = strobes.loadResult ? memRdData : aluOut;
  assign wbIdx    = strobes.dstIsRd ? rdIdx : rtIdx;
  assign wbEn     = strobes.regWrite & ~rst;

  rcore_regfile #(.DEPTH(REG_COUNT), .WIDTH(XLEN)) rf_i (
    .clk    (clk),
    .rst    (rst),
    .rdIdxA (rsIdx),
    .rdIdxB (rtIdx),
    .rdValA (rsVal),
    .rdValB (rtVal),
    .wrEn   (wbEn),
    .wrIdx  (wbIdx),
    .wrVal  (wbVal)
  );

  assign memAddr   = aluOut;
  assign memWrData = rtVal;
  assign memWrEn   = strobes.memWrite & ~rst;
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 128,
  localparam int IMEM_AW = $clog2(IMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imemLoadEn,
  input  logic [IMEM_AW-1:0] imemLoadIdx,
  input  logic [31:0]        imemLoadData,
  output logic [31:0]        pcOut,
  output logic [31:0]        dmemAddr,
  output logic [31:0]        dmemWrData,
  output logic               dmemWrEn,
  input  logic [31:0]        dmemRdData
);
  logic [XLEN-1:0] instrWord;
  logic [XLEN-1:0] rsVal;
  ctrl_t           strobes;
  logic            unusedShamt;

  rcore_imem #(.WORDS(IMEM_WORDS)) imem_i (
    .clk       (clk),
    .loadEn    (imemLoadEn),
    .loadIdx   (imemLoadIdx),
    .loadData  (imemLoadData),
    .fetchAddr (pcOut),
    .fetchWord (instrWord)
  );

  rcore_ctrl ctrl_i (
    .opcode  (instrWord[31:26]),
    .funct   (instrWord[5:0]),
    .strobes (strobes)
  );

  rcore_datapath dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .rsIdx     (instrWord[25:21]),
    .rtIdx     (instrWord[20:16]),
    .rdIdx     (instrWord[15:11]),
    .immField  (instrWord[15:0]),
    .pc        (pcOut),
    .rsVal     (rsVal),
    .memAddr   (dmemAddr),
    .memWrData (dmemWrData),
    .memWrEn   (dmemWrEn),
    .memRdData (dmemRdData)
  );

  assign unusedShamt = ^instrWord[10:6];
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
  import rcore_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic        dmemWrEn,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic [4:0]  rsIdx,
  input logic [31:0] rsVal,
  input logic        regWriteEn
);
  logic live = 1'b0;
  logic known;

  always_ff @(posedge clk) live <= ~rst;

  assign known = (opcode == OP_ADDI) || (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                 (opcode == OP_RTYPE && (funct == FN_ADD || funct == FN_SUB));

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pcOut == RESET_PC); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) live |-> pcOut == $past(pcOut) + 32'd4); // R2
  AST_LOAD_NO_STORE: assert property (@(posedge clk) disable iff (rst) (opcode == OP_LOAD) |-> regWriteEn && !dmemWrEn); // R6
  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst) dmemWrEn |-> opcode == OP_STORE); // R7
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst) (rsIdx == 5'd0) |-> rsVal == 32'd0); // R8
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst) !known |-> !dmemWrEn && !regWriteEn); // R9
endmodule

bind rcore_top rcore_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .pcOut      (pcOut),
  .dmemWrEn   (dmemWrEn),
  .opcode     (instrWord[31:26]),
  .funct      (instrWord[5:0]),
  .rsIdx      (instrWord[25:21]),
  .rsVal      (rsVal),
  .regWriteEn (strobes.regWrite)
);

// File: tb/rcore_top_tb_top.sv
module rcore_top_tb_top;
  localparam logic [31:0] BOOT = 32'h0040_0000;
  localparam int WORDS = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemLoadEn = 1'b0;
  logic [6:0]  imemLoadIdx = '0;
  logic [31:0] imemLoadData = '0;
  logic [31:0] pcOut, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWrEn;

  always #2 clk = ~clk;

  rcore_top dut_i (
    .clk(clk), .rst(rst), .imemLoadEn(imemLoadEn), .imemLoadIdx(imemLoadIdx),
    .imemLoadData(imemLoadData), .pcOut(pcOut), .dmemAddr(dmemAddr),
    .dmemWrData(dmemWrData), .dmemWrEn(dmemWrEn), .dmemRdData(dmemRdData)
  );

  logic [31:0] dmem [WORDS];
  assign dmemRdData = dmem[dmemAddr[8:2]];
  always @(posedge clk) if (dmemWrEn) dmem[dmemAddr[8:2]] <= dmemWrData;

  logic [31:0] prog [WORDS];
  int progLen = 0;
  logic [31:0] expAddr [64];
  logic [31:0] expData [64];
  string       expTag  [64];
  int expN = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  int logN = 0;
  int resetWrites = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (dmemWrEn) begin
      if (rst) resetWrites++;
      else if (logN < 64) begin
        logAddr[logN] = dmemAddr;
        logData[logN] = dmemWrData;
        logN++;
      end
    end
  end

  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic put(input logic [31:0] w);
    prog[progLen] = w;
    progLen++;
  endtask

  task automatic putStore(input int rt, input int base, input int off,
                          input logic [31:0] a, input logic [31:0] d, input string tag);
    put(encI(43, base, rt, off));
    expAddr[expN] = a;
    expData[expN] = d;
    expTag[expN]  = tag;
    expN++;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      prog[i] = '0;
      dmem[i] = '0;
    end
    dmem[8] = 32'h1234_5678;
    dmem[9] = 32'hCAFE_F00D;

    put(32'h8C0A0020);                                                    // R11 R6: r10 <- mem[32]
    putStore(7, 0, 200, 32'd200, 32'd0, "R1 register cleared");
    put(encI(8, 0, 17, 100));
    put(encI(8, 0, 18, -7));
    put(32'h02328020);                                                    // R11 R3: r16 = 93
    put(encI(8, 0, 19, 5));
    put(32'h2268FFF4);                                                    // R11 R5: r8 = -7
    putStore(8, 0, 0, 32'd0, 32'(5 - 12), "R5 R11 addi -12");
    put(encI(8, 0, 11, 20));
    put(encI(8, 0, 13, 6));
    put(32'h016D4022);                                                    // R11 R4: r8 = 14
    putStore(8, 0, 4, 32'd4, 32'd14, "R4 R11 sub");
    putStore(10, 0, 8, 32'd8, 32'h1234_5678, "R6 R11 load");
    putStore(16, 0, 12, 32'd12, 32'd93, "R3 R11 add");
    put(encI(8, 0, 0, 55));
    put(encR(17, 17, 0, 32));
    putStore(0, 0, 16, 32'd16, 32'd0, "R8 zero register");
    put(encI(8, 0, 5, 9));
    put(encR(17, 18, 5, 36));                                             // R9 unknown funct
    put(encI(63, 0, 5, 20));                                              // R9 unknown opcode
    put(encI(32, 0, 5, 4));                                               // R9 unlisted byte load
    putStore(5, 0, 20, 32'd20, 32'd9, "R9 register untouched");
    put(encI(8, 0, 20, 40));
    putStore(17, 20, -8, 32'd32, 32'd100, "R7 base plus negative offset");
    put(encI(35, 20, 21, -4));
    put(encR(18, 17, 22, 34));
    putStore(21, 0, 24, 32'd24, 32'hCAFE_F00D, "R6 load with base");
    putStore(22, 0, 28, 32'd28, 32'(-7 - 100), "R4 negative difference");
    put(encI(8, 0, 23, 32'h7FFF));
    put(encI(8, 23, 24, 32'h8000));
    putStore(24, 0, 40, 32'd40, 32'hFFFF_FFFF, "R5 immediate extremes");
    put(encI(35, 0, 25, 32));
    putStore(25, 0, 44, 32'd44, 32'd100, "R6 R7 store then load");
    for (int k = 1; k < 32; k++) put(encI(8, 0, k, k * 3 - 40));
    for (int k = 1; k < 32; k++)
      putStore(k, 0, 256 + 4 * k, 32'(256 + 4 * k), 32'(k * 3 - 40), "R10 register sweep");

    repeat (2) @(negedge clk);
    check(pcOut == BOOT, "R1 reset pc", pcOut, BOOT);
    check(dmemWrEn == 1'b0, "R1 no store in reset", 32'(dmemWrEn), 32'd0);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      imemLoadEn = 1'b1;
      imemLoadIdx = 7'(i);
      imemLoadData = prog[i];
    end
    @(negedge clk);
    imemLoadEn = 1'b0;
    #1 rst = 1'b0;

    for (int k = 1; k <= progLen + 2; k++) begin
      @(negedge clk);
      if (k == 1) check(pcOut == BOOT + 32'd4, "R2 first step", pcOut, BOOT + 32'd4);
      if (k == 20) check(pcOut == BOOT + 32'd80, "R2 R9 pc past unknown ops", pcOut, BOOT + 32'd80);
    end
    check(pcOut == BOOT + 32'(4 * (progLen + 2)), "R2 final pc", pcOut, BOOT + 32'(4 * (progLen + 2)));
    check(resetWrites == 0, "R1 stores during reset", 32'(resetWrites), 32'd0);
    check(logN == expN, "R7 R9 store count", 32'(logN), 32'(expN));
    for (int i = 0; i < expN; i++) begin
      if (i < logN) begin
        check(logAddr[i] == expAddr[i], {expTag[i], " address"}, logAddr[i], expAddr[i]);
        check(logData[i] == expData[i], {expTag[i], " data"}, logData[i], expData[i]);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule